// File: doc/BRIEF.md
# Power Mode Sequencer

This block holds the operating mode of a processor subsystem and drives the clock and supply controls from it. It has five modes: Full-On, Active, Sleep, Deep Sleep and Hibernate. From the mode it drives a PLL enable, a PLL bypass select, a core clock enable, a system clock enable and a core supply enable. It does not contain the PLL, the regulator or the clock gates. It only tells them what to do.

Software asks for a mode change through a valid/ready request port. A request completes in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only in Hibernate. While `req_ready` is low, a held request is neither acted on nor flagged, and it stays pending at the source. A completed request that breaks the transition rules leaves the mode unchanged and raises a one-cycle error pulse. A write of the hibernate code to the frequency field shuts the core supply down. Wakeup events and a real-time clock wakeup bring the block back out of the low-power modes.

All mode changes register on the clock edge that samples the cause. Outputs are decoded from the registered mode, so they change one cycle after the cause.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, the mode is Full-On: `mode_o`=0, `pll_en_o`=1, `pll_byp_o`=0, `cclk_en_o`=1, `sclk_en_o`=1, `vdd_en_o`=1, `err_o`=0.
- R2: Mode codes and the outputs (pll_en, byp, cclk, sclk, vdd) for each mode are:
  - Full-On (0): 1,0,1,1,1.
  - Active (1): `pll_en_in`,1,1,1,1.
  - Sleep (2): 1,`byp_in`,0,1,1.
  - Deep Sleep (3): 0,1,0,0,1.
  - Hibernate (4): 0,0,0,0,0.
- R3: In Full-On, a completed request for a different mode among 1, 2 or 3 moves to that mode in the next cycle without error. The same holds in Active for a request for Deep Sleep, and for Full-On or Sleep while `pll_en_in`=1.
- R4: In Active with `pll_en_in`=0, a request for Full-On or Sleep leaves the mode in Active and pulses `err_o`.
- R5: Each of the following completed requests is refused: a mode code of 4 to 7, or any request made in Sleep or Deep Sleep. A refused request keeps the mode and pulses `err_o`. A request for the current mode has no effect and no error.
- R6: In Sleep, `wake` or `rtc_wake` moves to Active when `byp_in`=1 and to Full-On when `byp_in`=0.
- R7: In Deep Sleep, `wake` or `rtc_wake` moves to Active.
- R8: In Full-On or Active, `freq_wr`=1 with `freq_ctl`=2'b00 enters Hibernate. A nonzero `freq_ctl`, or any `freq_wr` in Sleep or Deep Sleep, leaves the mode unchanged.
- R9: In Hibernate, `req_ready` is 0, and `wake` and requests have no effect. Only `rtc_wake` leaves Hibernate, and it goes to Full-On.
- R10: Some events can fall in the same cycle:
  - A hibernate write and a completed request: Hibernate is entered and the request is refused with `err_o`.
  - In Sleep, a wakeup and a request: the wakeup acts and the request is refused.
- R11: `err_o` is high for exactly the cycle after each refused request, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode change request present |
| req_ready | output | 1 | Requests accepted (low in Hibernate) |
| req_mode | input | 3 | Requested mode code |
| pll_en_in | input | 1 | Software PLL enable setting |
| byp_in | input | 1 | Software PLL bypass setting |
| freq_wr | input | 1 | Write strobe of the frequency field |
| freq_ctl | input | FREQ_W | Frequency field value; 0 selects Hibernate |
| wake | input | 1 | External wakeup event |
| rtc_wake | input | 1 | Real-time clock wakeup |
| pll_en_o | output | 1 | PLL enable |
| pll_byp_o | output | 1 | PLL bypass select |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| vdd_en_o | output | 1 | Core supply enable |
| mode_o | output | 3 | Current mode code |
| err_o | output | 1 | One-cycle refused-request flag |

## Verification
Two pairs of events can land on the same edge. The first is a hibernate write and a completed mode request in Full-On or Active. The second is a wakeup and a request while in Sleep. Directed steps drive each pair in a single cycle. The random phase also raises request, wakeup and frequency-write strobes independently, so these pairs occur again and again. A bench model that applies the stated priority judges every cycle. The priority is: the hibernate write wins, the wakeup wins, and the losing request is flagged.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_FULL = 3'd0,
    M_ACT  = 3'd1,
    M_SLP  = 3'd2,
    M_DSLP = 3'd3,
    M_HIB  = 3'd4
  } pmode_e;

  typedef struct packed {
    logic pll_en;
    logic pll_byp;
    logic cclk_en;
    logic sclk_en;
    logic vdd_en;
  } pctl_t;
endpackage

// File: rtl/pwr_req_check.sv
module pwr_req_check
  import pwr_pkg::*;
(
  input  pmode_e            mode,
  input  logic              req_fire,
  input  logic [MODE_W-1:0] req_code,
  input  logic              pll_on,
  input  logic              hib_hit,
  output logic              go,
  output pmode_e            target,
  output logic              refuse
);
  localparam logic [MODE_W-1:0] LAST_REQ = M_DSLP;

  logic [MODE_W-1:0] cur_code;
  logic              needs_pll;
  logic              core_idle;

  assign cur_code  = mode;
  assign needs_pll = (req_code == M_FULL) || (req_code == M_SLP);
  assign core_idle = (mode == M_SLP) || (mode == M_DSLP) || (mode == M_HIB);

  always_comb begin
    go     = 1'b0;
    refuse = 1'b0;
    target = mode;
    if (req_fire) begin
      if (hib_hit || core_idle) begin
        refuse = 1'b1;
      end else if (req_code == cur_code) begin
        go = 1'b0;
      end else if (req_code > LAST_REQ) begin
        refuse = 1'b1;
      end else if (mode == M_ACT && !pll_on && needs_pll) begin
        refuse = 1'b1;
      end else begin
        go     = 1'b1;
        target = pmode_e'(req_code);
      end
    end
  end
endmodule

// File: rtl/pwr_state.sv
module pwr_state
  import pwr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  pmode_e target,
  input  logic   refuse,
  input  logic   hib_hit,
  input  logic   wake,
  input  logic   rtc_wake,
  input  logic   byp_in,
  output pmode_e mode_q,
  output logic   err_q
);
  pmode_e nxt;
  logic   any_wake;

  assign any_wake = wake || rtc_wake;

  always_comb begin
    nxt = mode_q;
    if (hib_hit) begin
      nxt = M_HIB;
    end else begin
      unique case (mode_q)
        M_FULL, M_ACT: if (go) nxt = target;
        M_SLP:         if (any_wake) nxt = byp_in ? M_ACT : M_FULL;
        M_DSLP:        if (any_wake) nxt = M_ACT;
        M_HIB:         if (rtc_wake) nxt = M_FULL;
        default:       nxt = M_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FULL;
      err_q  <= 1'b0;
    end else begin
      mode_q <= nxt;
      err_q  <= refuse;
    end
  end

  assert_reset_full_R1: assert property (@(posedge clk)
    !rst_n |=> mode_q == M_FULL);

  assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLP && any_wake) |=> mode_q == ($past(byp_in) ? M_ACT : M_FULL));

  assert_dslp_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DSLP && any_wake) |=> mode_q == M_ACT);

  assert_hib_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HIB && !rtc_wake) |=> mode_q == M_HIB);

  assert_hib_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HIB && rtc_wake) |=> mode_q == M_FULL);
endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
  import pwr_pkg::*;
(
  input  pmode_e mode,
  input  logic   pll_on,
  input  logic   byp_sel,
  output pctl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (mode)
      M_FULL:  ctl = '{pll_en: 1'b1,   pll_byp: 1'b0,    cclk_en: 1'b1, sclk_en: 1'b1, vdd_en: 1'b1};
      M_ACT:   ctl = '{pll_en: pll_on, pll_byp: 1'b1,    cclk_en: 1'b1, sclk_en: 1'b1, vdd_en: 1'b1};
      M_SLP:   ctl = '{pll_en: 1'b1,   pll_byp: byp_sel, cclk_en: 1'b0, sclk_en: 1'b1, vdd_en: 1'b1};
      M_DSLP:  ctl = '{pll_en: 1'b0,   pll_byp: 1'b1,    cclk_en: 1'b0, sclk_en: 1'b0, vdd_en: 1'b1};
      M_HIB:   ctl = '0;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int                FREQ_W   = 2,
  parameter logic [FREQ_W-1:0] HIB_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              pll_en_in,
  input  logic              byp_in,
  input  logic              freq_wr,
  input  logic [FREQ_W-1:0] freq_ctl,
  input  logic              wake,
  input  logic              rtc_wake,
  output logic              pll_en_o,
  output logic              pll_byp_o,
  output logic              cclk_en_o,
  output logic              sclk_en_o,
  output logic              vdd_en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              err_o
);
  pmode_e mode_q;
  pmode_e target;
  pctl_t  ctl;
  logic   req_fire;
  logic   core_runs;
  logic   hib_hit;
  logic   go;
  logic   refuse;

  assign req_ready = (mode_q != M_HIB);
  assign req_fire  = req_valid && req_ready;
  assign core_runs = (mode_q == M_FULL) || (mode_q == M_ACT);
  assign hib_hit   = core_runs && freq_wr && (freq_ctl == HIB_CODE);

  pwr_req_check u_chk (
    .mode     (mode_q),
    .req_fire (req_fire),
    .req_code (req_mode),
    .pll_on   (pll_en_in),
    .hib_hit  (hib_hit),
    .go       (go),
    .target   (target),
    .refuse   (refuse)
  );

  pwr_state u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .target   (target),
    .refuse   (refuse),
    .hib_hit  (hib_hit),
    .wake     (wake),
    .rtc_wake (rtc_wake),
    .byp_in   (byp_in),
    .mode_q   (mode_q),
    .err_q    (err_o)
  );

  pwr_out_dec u_dec (
    .mode    (mode_q),
    .pll_on  (pll_en_in),
    .byp_sel (byp_in),
    .ctl     (ctl)
  );

  assign pll_en_o  = ctl.pll_en;
  assign pll_byp_o = ctl.pll_byp;
  assign cclk_en_o = ctl.cclk_en;
  assign sclk_en_o = ctl.sclk_en;
  assign vdd_en_o  = ctl.vdd_en;
  assign mode_o    = mode_q;

  assert_clk_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_en_o |-> (sclk_en_o && vdd_en_o));

  assert_legal_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FULL && req_valid && req_mode == M_SLP && !freq_wr) |=> mode_o == M_SLP);

  assert_pll_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ACT && req_valid && !pll_en_in && !freq_wr &&
     (req_mode == M_FULL || req_mode == M_SLP)) |=> (mode_o == M_ACT && err_o));

  assert_hib_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_runs && freq_wr && freq_ctl == HIB_CODE && req_valid) |=> (mode_o == M_HIB && err_o));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(req_valid && req_ready));
endmodule

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, pll_en_in = 1, byp_in = 0, freq_wr = 0, wake = 0, rtc_wake = 0;
  logic [2:0] req_mode = 0;
  logic [1:0] freq_ctl = 2'd3;
  logic req_ready, pll_en_o, pll_byp_o, cclk_en_o, sclk_en_o, vdd_en_o, err_o;
  logic [2:0] mode_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int exp_mode = 0;
  int exp_err = 0;

  always #10 clk = ~clk;

  pwr_mode_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .pll_en_in(pll_en_in), .byp_in(byp_in),
    .freq_wr(freq_wr), .freq_ctl(freq_ctl), .wake(wake), .rtc_wake(rtc_wake),
    .pll_en_o(pll_en_o), .pll_byp_o(pll_byp_o), .cclk_en_o(cclk_en_o),
    .sclk_en_o(sclk_en_o), .vdd_en_o(vdd_en_o), .mode_o(mode_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] dec(input int m, input logic pe, input logic by);
    case (m)
      0: return 5'b10111;
      1: return {pe, 4'b1111};
      2: return {1'b1, by, 3'b011};
      3: return 5'b01001;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk_all(input string tag);
    logic [4:0] e;
    e = dec(exp_mode, pll_en_in, byp_in);
    chk(tag, "mode", int'(mode_o), exp_mode);
    chk(tag, "err", int'(err_o), exp_err);
    chk("R9", "ready", int'(req_ready), int'(exp_mode != 4));
    chk("R2", "outs", int'({pll_en_o, pll_byp_o, cclk_en_o, sclk_en_o, vdd_en_o}), int'(e));
  endtask

  task automatic model;
    bit fire, hib, refuse;
    int nxt;
    fire = req_valid && (exp_mode != 4);
    hib = (exp_mode <= 1) && freq_wr && (freq_ctl == 2'd0);
    refuse = 0;
    nxt = exp_mode;
    if (hib) begin
      nxt = 4;
      refuse = fire;
    end else begin
      case (exp_mode)
        0, 1: if (fire && int'(req_mode) != exp_mode) begin
          if (req_mode > 3) refuse = 1;
          else if (exp_mode == 1 && !pll_en_in && (req_mode == 0 || req_mode == 2)) refuse = 1;
          else nxt = int'(req_mode);
        end
        2: begin
          refuse = fire;
          if (wake || rtc_wake) nxt = byp_in ? 1 : 0;
        end
        3: begin
          refuse = fire;
          if (wake || rtc_wake) nxt = 1;
        end
        default: if (rtc_wake) nxt = 0;
      endcase
    end
    exp_mode = nxt;
    exp_err = int'(refuse);
  endtask

  // called at a falling edge with inputs already set
  task automatic step(input string tag);
    model();
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic idle;
    req_valid = 0; wake = 0; rtc_wake = 0; freq_wr = 0;
  endtask

  task automatic req(input int code, input string tag);
    idle(); req_valid = 1; req_mode = 3'(code);
    step(tag);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk); @(negedge clk);
    exp_mode = 0; exp_err = 0;
    chk_all("R1");
    rst_n = 1;
    idle(); step("R1");

    // R3: Full-On to Active, R2 outputs in Active
    req(1, "R3");
    pll_en_in = 0; @(negedge clk); chk_all("R2");
    // R4: refused while PLL off
    req(0, "R4");
    req(2, "R4");
    idle(); step("R11");
    pll_en_in = 1;
    req(2, "R3");
    req(1, "R5");
    byp_in = 1; idle(); wake = 1; step("R6"); idle();
    req(1, "R5");
    req(3, "R3");
    idle(); freq_wr = 1; freq_ctl = 0; step("R8"); idle();
    req(0, "R5");
    rtc_wake = 1; step("R7"); idle();
    req(6, "R5");
    req(4, "R5");
    freq_ctl = 2; freq_wr = 1; step("R8"); idle();
    // R10: hibernate write and request together
    freq_ctl = 0; freq_wr = 1; req_valid = 1; req_mode = 3; step("R10"); idle();
    wake = 1; req_valid = 1; req_mode = 1; step("R9"); idle();
    step("R9");
    rtc_wake = 1; step("R9"); idle();
    req(2, "R3");
    byp_in = 0; wake = 1; req_valid = 1; req_mode = 1; step("R10"); idle();
    step("R11");

    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 10) < 3;
      req_mode  = 3'($urandom % 8);
      wake      = ($urandom % 10) == 0;
      rtc_wake  = ($urandom % 20) == 0;
      freq_wr   = ($urandom % 25) == 0;
      freq_ctl  = 2'($urandom % 4);
      pll_en_in = ($urandom % 5) != 0;
      byp_in    = 1'($urandom % 2);
      step("R3");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule